// File: doc/BRIEF.md
# Single-Wire Trim Pulse Decoder

This block turns timed pulses on one three-level control wire into single steps of a 7-bit trim code. The code drives a current-sink DAC that sets a display's common-electrode voltage. External comparators have already split the wire into two digital flags: one for a low level and one for a high level. When both flags are clear, the wire is at its middle, or floating, level. A pulse counts only if it is long enough, starts a minimum gap after the previous pulse, and ends cleanly back at the middle level. A long low pulse raises the code by one and a long high pulse lowers it by one.

An enable input gates the whole interface. Pulses are only accepted once the enable has been high for a start-up time. The first good pulse after that is thrown away, because it may be a false edge from power sequencing. A busy flag from the programming detector freezes the code while a non-volatile write is under way. A small register stands in for the non-volatile cell. It comes out of reset at half scale. It captures the live code on a commit strobe and gives its value back to the code on a reload strobe.

All timing is counted in ticks of a divided clock. The tick rate and every threshold are parameters. The defaults give 1 µs ticks, a 200 µs step width, a 20 µs glitch limit, a 10 µs gap and a 1 ms start-up time.

Top module: `trim_pulse_decoder`

## Requirements
- R1: The wire level is encoded as follows: `ctl_lo`=1 means low, `ctl_hi`=1 means high, and both 0 means middle. Both flags are never 1 together. A wire that stays at the middle level never changes the code.
- R2: A low level held for at least LONG_TICKS ticks raises `code` by one. The step is applied when the wire returns to the middle level, and `step_stb` is high for exactly one cycle with the step.
- R3: A high level held for at least LONG_TICKS ticks lowers `code` by one, with the same one-cycle `step_stb`.
- R4: A pulse shorter than GLITCH_TICKS changes nothing and raises no strobe. It also does not restart the gap timer, so a good pulse that follows it closely is still accepted.
- R5: A pulse lasting from GLITCH_TICKS up to LONG_TICKS is rejected with no strobe, and it restarts the gap timer.
- R6: A pulse that begins fewer than GAP_TICKS ticks after the previous non-glitch pulse ended is rejected.
- R7: A pulse that swings straight between low and high without passing through the middle level is rejected in both of its parts.
- R8: While `if_en` is low, and for STARTUP_TICKS ticks after it rises, the wire is ignored.
- R9: The first qualified pulse after the interface becomes ready is discarded with no step and no strobe. Dropping `if_en` re-arms this rule.
- R10: While `prog_busy` is high, qualified pulses are dropped with no step and no strobe. They do not use up the first-pulse discard.
- R11: The code saturates. A step up at 127 or a step down at 0 leaves the code unchanged, but `step_stb` still fires.
- R12: After reset, `code` is 64 and `step_stb` is 0. A `reload` cycle copies the stored value into `code` and takes priority over a step in the same cycle.
- R13: A `prog_commit` cycle copies the present `code` into the stored value. The stored value is otherwise held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| if_en | input | 1 | Interface enable |
| ctl_lo | input | 1 | Comparator flag: wire at low level |
| ctl_hi | input | 1 | Comparator flag: wire at high level |
| prog_busy | input | 1 | Non-volatile write in progress; freezes stepping |
| prog_commit | input | 1 | One-cycle strobe: store the present code |
| reload | input | 1 | One-cycle strobe: load the stored value into the code |
| code | output | CODE_W | Trim code driving the DAC |
| step_stb | output | 1 | One-cycle marker of each accepted step |

## Verification
The assertions rely on a few properties of the inputs:
- The comparators never raise both level flags at once.
- `rst_n` is driven low from time zero.
- `reload` and `prog_commit` are single-cycle strobes.

Everything else the assertions check is relation between the block's own stages: no event is issued while the interface is not ready, the code moves by at most one between reloads, and the code never wraps.

The directed stimulus keeps each pulse width and gap several ticks away from every threshold. This means tick-phase uncertainty of one tick cannot change the expected outcome. The bench drives only one flag at a time, or both flags clear.

// File: rtl/trim_pkg.sv
// Shared types for the trim pulse decoder.
// Assumes: the two comparator flags are decoded into one of three levels.
package trim_pkg;
    typedef enum logic [1:0] {
        LVL_MID  = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_HIGH = 2'd2
    } line_lvl_t;
endpackage

// File: rtl/trim_tick_gen.sv
// Divides the system clock down to the timing tick used by every counter.
// Assumes: CLK_HZ is an integer multiple of TICK_HZ (any remainder is dropped).
module trim_tick_gen #(
    parameter int CLK_HZ  = 50_000_000,
    parameter int TICK_HZ = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DIV = CLK_HZ / TICK_HZ;

    generate
        if (DIV <= 1) begin : g_passthru
            assign tick = 1'b1;
        end else begin : g_div
            localparam int DW = $clog2(DIV);
            localparam logic [DW-1:0] LAST = DW'(DIV - 1);
            logic [DW-1:0] cnt;

            // Free-running divider; tick marks the last count of each period
            always_ff @(posedge clk) begin
                if (!rst_n)           cnt <= '0;
                else if (cnt == LAST) cnt <= '0;
                else                  cnt <= cnt + DW'(1);
            end
            assign tick = (cnt == LAST);
        end
    endgenerate
endmodule

// File: rtl/trim_enable_gate.sv
// Opens the interface only after the enable has been high for the start-up time.
// Assumes: if_en is quasi-static and already synchronous to clk.
module trim_enable_gate #(
    parameter int STARTUP_TICKS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic if_en,
    output logic ready
);
    localparam int SW = $clog2(STARTUP_TICKS + 1);
    localparam logic [SW-1:0] ST_V = SW'(STARTUP_TICKS);
    logic [SW-1:0] cnt;

    // Count ticks while enabled; a low enable clears both count and ready
    always_ff @(posedge clk) begin
        if (!rst_n || !if_en) begin
            cnt   <= '0;
            ready <= 1'b0;
        end else if (cnt == ST_V) begin
            ready <= 1'b1;
        end else if (tick) begin
            cnt <= cnt + SW'(1);
        end
    end

    assert_ready_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> $past(if_en));
endmodule

// File: rtl/trim_line_qualifier.sv
// Synchronises the level flags, times each pulse and the gap before it,
// and issues one up or down event when a qualified pulse returns to mid.
// Assumes: GLITCH_TICKS < LONG_TICKS; the flags are never both high.
module trim_line_qualifier
    import trim_pkg::*;
#(
    parameter int LONG_TICKS   = 200,
    parameter int GLITCH_TICKS = 20,
    parameter int GAP_TICKS    = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic ready,
    input  logic line_lo,
    input  logic line_hi,
    output logic ev_up,
    output logic ev_dn
);
    localparam int WW = $clog2(LONG_TICKS + 1);
    localparam int GW = $clog2(GAP_TICKS + 1);
    localparam logic [WW-1:0] LONG_V   = WW'(LONG_TICKS);
    localparam logic [WW-1:0] GLITCH_V = WW'(GLITCH_TICKS);
    localparam logic [GW-1:0] GAP_V    = GW'(GAP_TICKS);

    logic      lo_m, lo_s, hi_m, hi_s;
    line_lvl_t lvl_now, p_lvl;
    logic      in_pulse, p_bad;
    logic [WW-1:0] width;
    logic [GW-1:0] gap;

    // Two-stage synchronisers for the comparator flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_m <= 1'b0; lo_s <= 1'b0;
            hi_m <= 1'b0; hi_s <= 1'b0;
        end else begin
            lo_m <= line_lo; lo_s <= lo_m;
            hi_m <= line_hi; hi_s <= hi_m;
        end
    end

    // Decode the synchronised flags into a level
    always_comb begin
        if (lo_s && !hi_s)      lvl_now = LVL_LOW;
        else if (hi_s && !lo_s) lvl_now = LVL_HIGH;
        else                    lvl_now = LVL_MID;
    end

    // Pulse tracker: width and gap timing, rejection flags, event issue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_pulse <= 1'b0;
            p_lvl    <= LVL_MID;
            p_bad    <= 1'b0;
            width    <= '0;
            gap      <= '0;
            ev_up    <= 1'b0;
            ev_dn    <= 1'b0;
        end else begin
            ev_up <= 1'b0;
            ev_dn <= 1'b0;
            if (!ready) begin
                in_pulse <= 1'b0;
                p_bad    <= 1'b0;
                width    <= '0;
                gap      <= '0;
            end else if (!in_pulse) begin
                if (lvl_now != LVL_MID) begin
                    in_pulse <= 1'b1;
                    p_lvl    <= lvl_now;
                    width    <= '0;
                    p_bad    <= (gap < GAP_V);
                end else if (tick && gap < GAP_V) begin
                    gap <= gap + GW'(1);
                end
            end else begin
                if (lvl_now == LVL_MID) begin
                    in_pulse <= 1'b0;
                    if (width >= GLITCH_V) gap <= '0;
                    if (width >= LONG_V && !p_bad) begin
                        ev_up <= (p_lvl == LVL_LOW);
                        ev_dn <= (p_lvl == LVL_HIGH);
                    end
                end else if (lvl_now != p_lvl) begin
                    p_lvl <= lvl_now;
                    width <= '0;
                    p_bad <= 1'b1;
                    gap   <= '0;
                end else if (tick && width < LONG_V) begin
                    width <= width + WW'(1);
                end
            end
        end
    end

    assert_flags_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(lo_s && hi_s));
    assert_event_at_mid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_up || ev_dn) |-> $past(lvl_now == LVL_MID));
    assert_no_event_unready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> !(ev_up || ev_dn));
endmodule

// File: rtl/trim_value_store.sv
// Stand-in for the non-volatile cell: holds the saved code.
// Assumes: prog_commit is a one-cycle strobe; reset models the factory state.
module trim_value_store #(
    parameter int CODE_W  = 7,
    parameter int FACTORY = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_commit,
    input  logic [CODE_W-1:0] code,
    output logic [CODE_W-1:0] store_q
);
    // Capture the live code on commit, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n)           store_q <= CODE_W'(FACTORY);
        else if (prog_commit) store_q <= code;
    end

    assert_store_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_commit |=> $stable(store_q));
endmodule

// File: rtl/trim_code_reg.sv
// Holds the trim code: applies events with saturation, discards the first
// event after ready, freezes during programming, and reloads on request.
// Assumes: ev_up and ev_dn are never high together.
module trim_code_reg #(
    parameter int CODE_W  = 7,
    parameter int FACTORY = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ready,
    input  logic              ev_up,
    input  logic              ev_dn,
    input  logic              prog_busy,
    input  logic              reload,
    input  logic [CODE_W-1:0] store_q,
    output logic [CODE_W-1:0] code,
    output logic              step_stb
);
    localparam logic [CODE_W-1:0] CODE_MAX = '1;
    localparam logic [CODE_W-1:0] CODE_MIN = '0;
    logic first_pending;

    // Code update, first-pulse discard and strobe generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code          <= CODE_W'(FACTORY);
            first_pending <= 1'b1;
            step_stb      <= 1'b0;
        end else begin
            step_stb <= 1'b0;
            if (!ready) first_pending <= 1'b1;
            if (reload) begin
                code <= store_q;
            end else if ((ev_up || ev_dn) && ready && !prog_busy) begin
                if (first_pending) begin
                    first_pending <= 1'b0;
                end else begin
                    step_stb <= 1'b1;
                    if (ev_up && code != CODE_MAX) code <= code + CODE_W'(1);
                    if (ev_dn && code != CODE_MIN) code <= code - CODE_W'(1);
                end
            end
        end
    end

    assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !reload |=> (code == $past(code) || code == $past(code) + CODE_W'(1)
                     || code == $past(code) - CODE_W'(1)));
    assert_no_wrap_top_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload && code == CODE_MAX) |=> code != CODE_MIN);
    assert_no_wrap_bottom_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload && code == CODE_MIN) |=> code != CODE_MAX);
    assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_busy && !reload) |=> $stable(code));
    assert_strobe_needs_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        step_stb |-> $past(ready));
    assert_reset_value_R12: assert property (@(posedge clk)
        !rst_n |=> (code == CODE_W'(FACTORY) && !step_stb));
endmodule

// File: rtl/trim_pulse_decoder.sv
// Top level: single-wire pulse command decoder driving a 7-bit trim code.
// Assumes: comparator flags are mutually exclusive; all inputs share clk.
module trim_pulse_decoder #(
    parameter int CLK_HZ        = 50_000_000,
    parameter int TICK_HZ       = 1_000_000,
    parameter int LONG_TICKS    = 200,
    parameter int GLITCH_TICKS  = 20,
    parameter int GAP_TICKS     = 10,
    parameter int STARTUP_TICKS = 1000,
    parameter int CODE_W        = 7,
    parameter int FACTORY       = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              if_en,
    input  logic              ctl_lo,
    input  logic              ctl_hi,
    input  logic              prog_busy,
    input  logic              prog_commit,
    input  logic              reload,
    output logic [CODE_W-1:0] code,
    output logic              step_stb
);
    logic              tick, ready, ev_up, ev_dn;
    logic [CODE_W-1:0] store_q;

    trim_tick_gen #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    trim_enable_gate #(.STARTUP_TICKS(STARTUP_TICKS)) u_gate (
        .clk(clk), .rst_n(rst_n), .tick(tick), .if_en(if_en), .ready(ready)
    );

    trim_line_qualifier #(
        .LONG_TICKS(LONG_TICKS), .GLITCH_TICKS(GLITCH_TICKS), .GAP_TICKS(GAP_TICKS)
    ) u_qual (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ready(ready),
        .line_lo(ctl_lo), .line_hi(ctl_hi), .ev_up(ev_up), .ev_dn(ev_dn)
    );

    trim_value_store #(.CODE_W(CODE_W), .FACTORY(FACTORY)) u_store (
        .clk(clk), .rst_n(rst_n), .prog_commit(prog_commit),
        .code(code), .store_q(store_q)
    );

    trim_code_reg #(.CODE_W(CODE_W), .FACTORY(FACTORY)) u_code (
        .clk(clk), .rst_n(rst_n), .ready(ready), .ev_up(ev_up), .ev_dn(ev_dn),
        .prog_busy(prog_busy), .reload(reload), .store_q(store_q),
        .code(code), .step_stb(step_stb)
    );
endmodule

// File: tb/test_trim_pulse_decoder.sv
// Directed bench: one task per scenario, each checking its own results.
module test_trim_pulse_decoder;
    localparam int LONG_C   = 60;  // 12 ticks, threshold 8
    localparam int MED_C    = 25;  // 5 ticks, between 3 and 8
    localparam int GLITCH_C = 5;   // 1 tick, below 3
    localparam int GAP_OK   = 40;  // 8 ticks, gap needs 3
    localparam int GAP_BAD  = 5;   // 1 tick

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic if_en = 1'b0, ctl_lo = 1'b0, ctl_hi = 1'b0;
    logic prog_busy = 1'b0, prog_commit = 1'b0, reload = 1'b0;
    logic [6:0] code;
    logic step_stb;
    int n_cmp = 0, n_bad = 0, stb_cnt = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    trim_pulse_decoder #(
        .CLK_HZ(50_000_000), .TICK_HZ(10_000_000), .LONG_TICKS(8),
        .GLITCH_TICKS(3), .GAP_TICKS(3), .STARTUP_TICKS(20)
    ) i_trim_pulse_decoder (
        .clk(clk), .rst_n(rst_n), .if_en(if_en), .ctl_lo(ctl_lo), .ctl_hi(ctl_hi),
        .prog_busy(prog_busy), .prog_commit(prog_commit), .reload(reload),
        .code(code), .step_stb(step_stb)
    );

    always @(negedge clk) if (rst_n && step_stb) stb_cnt++;

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(bit high, int w, int gap);
        ctl_lo = !high; ctl_hi = high;
        wait_cyc(w);
        ctl_lo = 1'b0; ctl_hi = 1'b0;
        wait_cyc(gap);
    endtask

    task automatic step_chk(string req, bit high, int w, int exp_code, int exp_stb);
        int s0 = stb_cnt;
        pulse(high, w, GAP_OK);
        chk({req, " code"}, code, exp_code);
        chk({req, " strobes"}, stb_cnt - s0, exp_stb);
    endtask

    task automatic t_reset;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(2);
        chk("R12 reset code", code, 64);
        chk("R12 reset strobe", step_stb, 0);
        wait_cyc(50);
        chk("R1 idle mid keeps code", code, 64);
    endtask

    task automatic t_enable;
        step_chk("R8 disabled", 1'b0, LONG_C, 64, 0);
        if_en = 1'b1;
        step_chk("R8 startup", 1'b0, LONG_C, 64, 0);
        wait_cyc(100);
    endtask

    task automatic t_first_and_steps;
        step_chk("R9 first discarded", 1'b0, LONG_C, 64, 0);
        step_chk("R2 low step up", 1'b0, LONG_C, 65, 1);
        step_chk("R3 high step down", 1'b1, LONG_C, 64, 1);
    endtask

    task automatic t_glitch;
        int s0;
        step_chk("R4 glitch ignored", 1'b0, GLITCH_C, 64, 0);
        s0 = stb_cnt;
        pulse(1'b0, GLITCH_C, GAP_BAD);
        pulse(1'b0, LONG_C, GAP_OK);
        chk("R4 glitch keeps gap", code, 65);
        chk("R4 glitch keeps gap strobes", stb_cnt - s0, 1);
    endtask

    task automatic t_medium_gap;
        int s0;
        step_chk("R5 medium rejected", 1'b0, MED_C, 65, 0);
        s0 = stb_cnt;
        pulse(1'b0, MED_C, GAP_BAD);
        pulse(1'b0, LONG_C, GAP_OK);
        chk("R5 medium restarts gap", code, 65);
        chk("R5 medium restarts gap strobes", stb_cnt - s0, 0);
        s0 = stb_cnt;
        pulse(1'b0, LONG_C, GAP_BAD);
        pulse(1'b0, LONG_C, GAP_OK);
        chk("R6 short gap rejects second", code, 66);
        chk("R6 short gap strobes", stb_cnt - s0, 1);
    endtask

    task automatic t_swing;
        int s0 = stb_cnt;
        ctl_lo = 1'b1; wait_cyc(LONG_C);
        ctl_lo = 1'b0; ctl_hi = 1'b1; wait_cyc(LONG_C);
        ctl_hi = 1'b0; wait_cyc(GAP_OK);
        chk("R7 direct swing code", code, 66);
        chk("R7 direct swing strobes", stb_cnt - s0, 0);
    endtask

    task automatic t_busy_commit;
        prog_busy = 1'b1;
        step_chk("R10 busy freeze", 1'b1, LONG_C, 66, 0);
        prog_busy = 1'b0;
        step_chk("R10 after busy", 1'b1, LONG_C, 65, 1);
        prog_commit = 1'b1; wait_cyc(1); prog_commit = 1'b0;
        step_chk("R13 step after commit", 1'b0, LONG_C, 66, 1);
        reload = 1'b1; wait_cyc(1); reload = 1'b0;
        wait_cyc(3);
        chk("R13 reload restores stored", code, 65);
        chk("R12 reload path", code, 65);
    endtask

    task automatic t_rearm;
        if_en = 1'b0; wait_cyc(10);
        if_en = 1'b1; wait_cyc(150);
        prog_busy = 1'b1;
        step_chk("R10 busy pulse after enable", 1'b0, LONG_C, 65, 0);
        prog_busy = 1'b0;
        step_chk("R9 rearmed discard", 1'b0, LONG_C, 65, 0);
        step_chk("R9 after discard", 1'b0, LONG_C, 66, 1);
    endtask

    task automatic t_saturate;
        for (int i = 0; i < 61; i++) pulse(1'b0, LONG_C, GAP_OK);
        chk("R11 reached top", code, 127);
        step_chk("R11 hold at top", 1'b0, LONG_C, 127, 1);
        for (int i = 0; i < 127; i++) pulse(1'b1, LONG_C, GAP_OK);
        chk("R11 reached bottom", code, 0);
        step_chk("R11 hold at bottom", 1'b1, LONG_C, 0, 1);
    endtask

    initial begin
        t_reset();
        t_enable();
        t_first_and_steps();
        t_glitch();
        t_medium_gap();
        t_swing();
        t_busy_commit();
        t_rearm();
        t_saturate();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule